// File: doc/BRIEF.md
# Cascadable Sample Interval Generator

This block produces the conversion-start pulse train for an analog input path. An interval counter counts down ticks from one of two sources and, each time it reaches terminal count, issues a single conversion-start pulse and reloads. The first source is a fixed 1 MHz timebase. The second is a prescaling counter that is itself programmable and runs from a fixed 2 MHz timebase. Chaining the two counters stretches the range of sample periods well beyond what the interval counter alone can reach.

Both timebases are single-cycle enable pulses derived from the system clock, so the whole block lives in one clock domain. `SYS_PER_FAST` sets how many system clocks make one 2 MHz period (default 4, i.e. an 8 MHz system clock). Software writes an 8-bit command word, of which one bit picks the source. It supplies the interval and prescale counts as plain inputs and starts or stops the pulse train with a run enable. Dropping the run enable parks both counters and the timebase phase, so every run starts from a clean, predictable point.

Top module: `sample_interval_gen`

## Requirements
- R1: After reset, `conv_start` is low, and it stays low for as long as `run_en` has not been raised.
- R2: With the source bit clear, the run-enable rising edge is counted as system edge 0. Pulses then follow at edges N·2·SYS_PER_FAST, 2·N·2·SYS_PER_FAST and so on, so the sample period is N microseconds. N is `interval_count`.
- R3: With the source bit set, the interval counter counts terminal counts of the prescaling counter. That counter runs on the 2 MHz enable with count P (`prescale_count`). Pulses then follow every N·P·SYS_PER_FAST system edges, the first one at that edge after the run-enable rising edge.
- R4: The source bit is bit 3 of the command word, captured on `cmd_we` (0 = 1 MHz timebase, 1 = cascaded prescaler). All other command bits have no effect on the pulse timing.
- R5: An interval count of 0 behaves as 2^CNT_W ticks and never stalls the pulse train.
- R6: A prescale count of 0 behaves as 2^CNT_W ticks of the 2 MHz timebase.
- R7: A change of the source bit during a run does not affect the interval in progress. It is taken up at the next interval reload. A cascaded interval always begins with a freshly reloaded prescaler. A 1 MHz interval counts from the next 1 MHz tick after the reload.
- R8: Every conversion-start pulse is exactly one system clock wide.
- R9: Lowering `run_en` suppresses any further pulse from the next clock on. It also discards the interval in progress, so a later run restarts timing from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 8 | Command word; bit 3 selects the interval source |
| run_en | input | 1 | Enables the pulse train; low parks all counters |
| interval_count | input | CNT_W | Sample interval count N, sampled at each interval reload |
| prescale_count | input | CNT_W | Prescaler count P, sampled at each prescaler reload |
| conv_start | output | 1 | One-cycle conversion-start pulse |

## Verification
The hardest case to reach is a source change that lands on a reload edge which is a 2 MHz tick but not a 1 MHz tick. In that case the first 1 MHz interval is shortened by the phase of the timebase, not by a whole period. The bench gets there by running the cascade with an odd N·P product (N=1, P=3), so the reload falls halfway through a 1 MHz period, and by writing the select bit partway into that interval. The opposite switch is also driven: a write lands in the middle of a 1 MHz interval, to show that the current period completes unchanged and that the prescaler restarts at the reload. The scoreboard predicts every pulse edge from the rules above.

// File: rtl/sig_pkg.sv
package sig_pkg;
    // Position of the source-select field in the command word; decoded by the top.
    localparam int unsigned SEL_BIT = 3;
    localparam int unsigned CMD_W   = 8;

    typedef enum logic {
        SRC_FIXED   = 1'b0,   // interval counter ticks on the 1 MHz enable
        SRC_CASCADE = 1'b1    // interval counter ticks on prescaler terminal count
    } sig_src_e;
endpackage

// File: rtl/sig_timebase.sv
// Derives 2 MHz and 1 MHz single-cycle enables from the system clock.
module sig_timebase #(
    parameter int unsigned SYS_PER_FAST = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic fast_en,
    output logic slow_en
);
    localparam int unsigned DW = (SYS_PER_FAST > 2) ? $clog2(SYS_PER_FAST) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(SYS_PER_FAST - 1);

    typedef struct packed {
        logic [DW-1:0] div;
        logic          phase;
    } tb_st_t;

    tb_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        fast_en = run && (st_q.div == DIV_LAST);
        slow_en = fast_en && st_q.phase;
        if (!run) begin
            st_d = '0;
        end else if (fast_en) begin
            st_d.div   = '0;
            st_d.phase = ~st_q.phase;
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sig_reload_ctr.sv
// Down-counter with reload: period of exactly load_val ticks, 0 meaning 2^W.
module sig_reload_ctr #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         restart,
    input  logic         tick_en,
    input  logic [W-1:0] load_val,
    output logic         tc
);
    typedef struct packed {
        logic [W-1:0] cnt;   // remaining ticks minus one
    } ctr_st_t;

    ctr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tc   = tick_en && !hold && (st_q.cnt == '0);
        if (hold || restart || tc) begin
            // 0 - 1 wraps to all ones, giving the full 2^W period
            st_d.cnt = load_val - W'(1);
        end else if (tick_en) begin
            st_d.cnt = st_q.cnt - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sample_interval_gen.sv
module sample_interval_gen
    import sig_pkg::*;
#(
    parameter int unsigned CNT_W        = 8,
    parameter int unsigned SYS_PER_FAST = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [CMD_W-1:0] cmd_wdata,
    input  logic             run_en,
    input  logic [CNT_W-1:0] interval_count,
    input  logic [CNT_W-1:0] prescale_count,
    output logic             conv_start
);
    typedef struct packed {
        logic     run;       // registered run enable; low parks everything
        logic     cmd_sel;   // source bit as last written
        sig_src_e int_sel;   // source in force for the current interval
        logic     start;     // conversion-start pulse
    } top_st_t;

    top_st_t st_d, st_q;

    logic hold;
    logic fast_en, slow_en;
    logic pre_tc, int_tc, int_tick;
    logic cmd_sel_bit, int_sel_bit;

    assign hold = !st_q.run;

    sig_timebase #(.SYS_PER_FAST(SYS_PER_FAST)) u_timebase (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q.run),
        .fast_en (fast_en),
        .slow_en (slow_en)
    );

    // Prescaler restarts on every interval reload so each cascaded interval
    // is a whole number of prescaler periods.
    sig_reload_ctr #(.W(CNT_W)) u_prescale (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .restart  (int_tc),
        .tick_en  (fast_en),
        .load_val (prescale_count),
        .tc       (pre_tc)
    );

    sig_reload_ctr #(.W(CNT_W)) u_interval (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .restart  (1'b0),
        .tick_en  (int_tick),
        .load_val (interval_count),
        .tc       (int_tc)
    );

    always_comb begin
        st_d     = st_q;
        int_tick = (st_q.int_sel == SRC_CASCADE) ? pre_tc : slow_en;

        st_d.run = run_en;
        if (cmd_we) begin
            st_d.cmd_sel = cmd_wdata[SEL_BIT];
        end
        // Source change is applied only when the interval counter reloads.
        if (hold || int_tc) begin
            st_d.int_sel = sig_src_e'(st_q.cmd_sel);
        end
        st_d.start = run_en && int_tc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.run     <= 1'b0;
            st_q.cmd_sel <= 1'b0;
            st_q.int_sel <= SRC_FIXED;
            st_q.start   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign conv_start  = st_q.start;
    assign cmd_sel_bit = st_q.cmd_sel;
    assign int_sel_bit = st_q.int_sel;
endmodule

// File: rtl/sample_interval_chk.sv
module sample_interval_chk (
    input logic clk,
    input logic rst_n,
    input logic run_en,
    input logic run_q,
    input logic cmd_we,
    input logic cmd_bit,
    input logic cmd_sel,
    input logic int_sel,
    input logic int_reload,
    input logic int_tick,
    input logic conv_start
);
    // R8: pulse is a single clock wide
    p_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R9 / R1: no pulse once run is low
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !conv_start);

    // R7: source in force changes only at a reload or while parked
    p_sel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !int_reload) |=> $stable(int_sel));

    // R4: command bit 3 is what the source register holds after a write
    p_cmd_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we |=> (cmd_sel == $past(cmd_bit)));

    // R2 / R3: every pulse follows a tick into the interval counter
    p_start_after_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(int_tick));
endmodule

bind sample_interval_gen sample_interval_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .run_q      (st_q.run),
    .cmd_we     (cmd_we),
    .cmd_bit    (cmd_wdata[3]),
    .cmd_sel    (cmd_sel_bit),
    .int_sel    (int_sel_bit),
    .int_reload (int_tc),
    .int_tick   (int_tick),
    .conv_start (conv_start)
);

// File: tb/tb_sample_interval_gen.sv
module tb_sample_interval_gen;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;
    localparam int DIV        = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_we = 1'b0;
    logic [7:0]       cmd_wdata = '0;
    logic             run_en = 1'b0;
    logic [CNT_W-1:0] ival = '0;
    logic [CNT_W-1:0] pval = '0;
    logic             conv_start;

    always #(CLK_PERIOD/2) clk = ~clk;

    sample_interval_gen #(.CNT_W(CNT_W), .SYS_PER_FAST(DIV)) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_we         (cmd_we),
        .cmd_wdata      (cmd_wdata),
        .run_en         (run_en),
        .interval_count (ival),
        .prescale_count (pval),
        .conv_start     (conv_start)
    );

    typedef struct {
        int    edge_i;
        string tag;
    } exp_t;

    exp_t  expq[$];
    int    checks = 0;
    int    fails = 0;
    int    unexpected = 0;
    int    last_edge = -1;
    logic  prev_start = 1'b0;
    string cur_tag = "R1";

    // Edge index since run rose: the first edge with run high is edge 0.
    always @(posedge clk) begin
        if (run_en) last_edge <= last_edge + 1;
        else        last_edge <= -1;
    end

    // Monitor: pops expected pulse edges and compares.
    always @(negedge clk) begin
        if (conv_start) begin
            if (prev_start) begin
                checks++; fails++;
                $display("FAIL R8: pulse width >1 at edge %0d, actual high, expected low", last_edge);
            end
            if (expq.size() == 0) begin
                checks++; fails++; unexpected++;
                $display("FAIL %s: unexpected pulse at edge %0d, expected none", cur_tag, last_edge);
            end else begin
                exp_t e;
                e = expq.pop_front();
                checks++;
                if (e.edge_i != last_edge) begin
                    fails++;
                    $display("FAIL %s: pulse at edge %0d, expected %0d", e.tag, last_edge, e.edge_i);
                end
            end
        end
        prev_start <= conv_start;
    end

    function automatic int eff(int v);
        return (v == 0) ? (1 << CNT_W) : v;
    endfunction

    // Next pulse edge after a reload at edge e.
    function automatic int nxt(int e, bit sel, int n, int p);
        int s;
        if (sel) return e + eff(n) * eff(p) * DIV;
        s = e + 1;
        while (s % (2 * DIV) != 0) s++;
        return s + (eff(n) - 1) * 2 * DIV;
    endfunction

    task automatic write_cmd(input logic [7:0] v);
        @(negedge clk);
        cmd_wdata = v; cmd_we = 1'b1;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    // Driver: predicts pulse edges, pushes them, runs, then checks nothing is left.
    task automatic run_case(input string tag, input logic [7:0] cmd0, input int n, input int p,
                            input int npulse, input int sw_at, input logic [7:0] cmd1);
        int  e;
        int  last;
        bit  sel;
        write_cmd(cmd0);
        ival = CNT_W'(n); pval = CNT_W'(p);
        cur_tag = tag;
        e = 0; sel = cmd0[3]; last = 0;
        for (int i = 0; i < npulse; i++) begin
            if (sw_at >= 0 && sw_at + 1 < e) sel = cmd1[3];
            e = nxt(e, sel, n, p);
            expq.push_back('{e, tag});
            last = e;
        end
        @(negedge clk);
        run_en = 1'b1;
        while (last_edge < last + 3) begin
            @(negedge clk);
            cmd_we = 1'b0;
            if (sw_at >= 0 && last_edge == sw_at) begin
                cmd_wdata = cmd1; cmd_we = 1'b1;
            end
        end
        cmd_we = 1'b0;
        run_en = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (expq.size() != 0) begin
            fails++;
            $display("FAIL %s: %0d pulses missing, expected 0", tag, expq.size());
        end
        expq.delete();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++; fails++;
        $display("FAIL R9: watchdog expired, actual hung, expected completion");
        summary();
        $finish;
    end

    initial begin
        int u0;
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (conv_start !== 1'b0) begin
            fails++;
            $display("FAIL R1: conv_start after reset %b, expected 0", conv_start);
        end
        rst_n = 1'b1;
        ival = 8'd1; pval = 8'd1;
        repeat (40) @(negedge clk);
        checks++;
        if (unexpected != 0 || conv_start !== 1'b0) begin
            fails++;
            $display("FAIL R1: idle pulses %0d, expected 0", unexpected);
        end

        // R2: 1 MHz source, several counts
        run_case("R2", 8'h00, 3, 5, 3, -1, 8'h00);
        run_case("R2", 8'h00, 1, 7, 3, -1, 8'h00);
        // R4: every bit except bit 3 set -> still 1 MHz source
        run_case("R4", 8'hF7, 2, 9, 2, -1, 8'h00);
        // R3: cascaded source
        run_case("R3", 8'h08, 2, 5, 2, -1, 8'h00);
        run_case("R3", 8'h08, 1, 1, 4, -1, 8'h00);
        // R4: only bit 3 set selects cascade
        run_case("R4", 8'h08, 3, 2, 2, -1, 8'h00);
        // R5: interval count 0 -> 2^CNT_W microseconds
        run_case("R5", 8'h00, 0, 3, 1, -1, 8'h00);
        // R6: prescale count 0 -> 2^CNT_W fast ticks
        run_case("R6", 8'h08, 1, 0, 1, -1, 8'h00);
        // R7: switch to cascade mid-interval; current 1 MHz period completes
        run_case("R7", 8'h00, 3, 5, 3, 30, 8'h08);
        // R7: switch back to 1 MHz with odd N*P; reload on a half-period phase
        run_case("R7", 8'h08, 1, 3, 3, 5, 8'h00);

        // R9: abort mid-interval, nothing comes out
        write_cmd(8'h00);
        ival = 8'd3; cur_tag = "R9";
        u0 = unexpected;
        @(negedge clk);
        run_en = 1'b1;
        while (last_edge < 10) @(negedge clk);
        run_en = 1'b0;
        repeat (40) @(negedge clk);
        checks++;
        if (unexpected != u0) begin
            fails++;
            $display("FAIL R9: pulses after abort %0d, expected 0", unexpected - u0);
        end
        // R9: restart after abort begins timing from zero
        run_case("R9", 8'h00, 3, 1, 2, -1, 8'h00);

        summary();
        $finish;
    end
endmodule